// File: doc/BRIEF.md
# Locked Index/Data Configuration Register Port

This block is a byte-wide configuration register file that a host reaches through two adjacent I/O addresses. The lower address is the index port and the upper one is the data port. After reset the file is sealed. It opens only when a four-byte entry key is written to the index port in the correct order. While it is open, a byte written to the index port becomes the register pointer. A read or write on the data port then reaches the register that the pointer selects.

The lower 48 registers form a global area that every logical device shares. It holds two fixed identification bytes, a device-select register and a command register. A command write seals the file again. Registers 0x30 through 0xFF form one bank per logical device, and the device-select register picks the bank in use. Every register is plain storage; the device functions behind them are outside this block.

Top module: `cfgport_top`

## Requirements
- R1: After reset the file is sealed, the device-select register and all global registers hold 0x00, and `io_rdata` holds 0xFF.
- R2: Writing 0x87, 0x01, 0x55, 0x55 to the index port (address 0x2E) opens the file. While the file is open, a read of the index port returns the current pointer.
- R3: A byte that does not match the expected key byte restarts key matching. If that byte is 0x87, it is counted as the first byte of a new attempt, so 0x87 0x01 0x55 0x87 0x01 0x55 0x55 opens the file.
- R4: While the file is sealed, reads of the data port (address 0x2F) and of the index port return 0xFF, and writes to the data port change no register.
- R5: While the file is open, writing an index to 0x2E and then writing 0x2F stores the byte in the register at that index. A later data-port read at that index returns the byte.
- R6: Registers 0x20 and 0x21 read 0x87 and 0x20. Writes to them are ignored.
- R7: Register 0x07 holds the logical device number. For pointers 0x30 to 0xFF, each device number below N_LDN (8 by default) reaches its own independent bank.
- R8: Registers 0x00 to 0x2F are shared, so they read the same values whatever device number is selected.
- R9: Writing 0x02 to register 0x02 seals the file. Any other value written there leaves it open. Register 0x02 reads 0x00.
- R10: With a device number of N_LDN or above, banked reads return 0x00 and banked writes are dropped.
- R11: `io_rdata` is updated on the clock edge that samples `io_rd` and holds between reads. Reads of any address other than the two ports return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte, registered |

## Verification
The bench sends broken key attempts, including one where a stray 0x87 has to start a fresh match. A matcher that simply resets to zero would stay sealed there. It also makes a sealed data write and checks that no register changed, which a port that ignores the seal would fail. It sweeps every banked register of every device and reads each one back, so a bank select that aliases devices would return another device's pattern. It also rereads the global area under a different device number. A device number past the last bank must read zero and must not clobber bank 0. The command register must seal the file only on the exact value 0x02, and the ID bytes must survive writes.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   typedef logic [7:0] byte_t;

   localparam byte_t ID_HI       = 8'h87;
   localparam byte_t ID_LO       = 8'h20;
   localparam byte_t REG_CMD     = 8'h02;
   localparam byte_t REG_LDN     = 8'h07;
   localparam byte_t REG_ID_HI   = 8'h20;
   localparam byte_t REG_ID_LO   = 8'h21;
   localparam byte_t CMD_EXIT    = 8'h02;
   localparam byte_t BANK_BASE   = 8'h30;
   localparam int    GLOBAL_REGS = 48;
   localparam int    BANK_REGS   = 256 - GLOBAL_REGS;

   function automatic byte_t key_byte(input logic [1:0] pos);
      case (pos)
         2'd0:    key_byte = 8'h87;
         2'd1:    key_byte = 8'h01;
         default: key_byte = 8'h55;
      endcase
   endfunction
endpackage

// File: rtl/cfgport_key.sv
module cfgport_key
   import cfgport_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  idx_wr,
   input  byte_t wdata,
   input  logic  relock,
   output logic  unlocked
);
   logic [1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         cnt      <= 2'd0;
      end else if (relock) begin
         unlocked <= 1'b0;
         cnt      <= 2'd0;
      end else if (!unlocked && idx_wr) begin
         if (wdata == key_byte(cnt)) begin
            if (cnt == 2'd3) begin
               unlocked <= 1'b1;
               cnt      <= 2'd0;
            end else begin
               cnt <= cnt + 2'd1;
            end
         end else if (wdata == key_byte(2'd0)) begin
            cnt <= 2'd1;
         end else begin
            cnt <= 2'd0;
         end
      end
   end

   // R2: opening only follows an index write of the final key byte
   a_r2_open_on_last_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(idx_wr && wdata == 8'h55));

   // R3: a lead byte while sealed always leaves exactly one byte matched
   a_r3_lead_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && idx_wr && !relock && wdata == 8'h87) |=> (cnt == 2'd1 && !unlocked));
endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
   import cfgport_pkg::*;
#(
   parameter int N_LDN = 8
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  byte_t ptr,
   input  byte_t wdata,
   output byte_t rd_val,
   output logic  exit_cmd
);
   localparam int         LDN_W   = $clog2(N_LDN);
   localparam logic [8:0] N_LDN_V = 9'(N_LDN);

   if (N_LDN < 2 || N_LDN > 256) begin : g_bad_ldn
      $error("cfgport_regs: N_LDN must be 2..256");
   end

   byte_t glob [GLOBAL_REGS];
   byte_t bank_rd [N_LDN];
   logic  is_bank, ldn_ok;
   logic [LDN_W-1:0] ldn_sel;
   byte_t bank_off;
   byte_t ldn;

   assign ldn      = glob[REG_LDN[5:0]];
   assign is_bank  = (ptr >= BANK_BASE);
   assign ldn_ok   = ({1'b0, ldn} < N_LDN_V);
   assign ldn_sel  = ldn[LDN_W-1:0];
   assign bank_off = ptr - BANK_BASE;
   assign exit_cmd = wr_en && (ptr == REG_CMD) && (wdata == CMD_EXIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < GLOBAL_REGS; i++) glob[i] <= 8'h00;
      end else if (wr_en && !is_bank && ptr != REG_CMD &&
                   ptr != REG_ID_HI && ptr != REG_ID_LO) begin
         glob[ptr[5:0]] <= wdata;
      end
   end

   for (genvar g = 0; g < N_LDN; g++) begin : g_bank
      byte_t mem [BANK_REGS];
      always_ff @(posedge clk) begin
         if (wr_en && is_bank && ldn_ok && ldn_sel == LDN_W'(g))
            mem[bank_off] <= wdata;
      end
      assign bank_rd[g] = mem[bank_off];
   end

   always_comb begin
      if (is_bank)                rd_val = ldn_ok ? bank_rd[ldn_sel] : 8'h00;
      else if (ptr == REG_CMD)    rd_val = 8'h00;
      else if (ptr == REG_ID_HI)  rd_val = ID_HI;
      else if (ptr == REG_ID_LO)  rd_val = ID_LO;
      else                        rd_val = glob[ptr[5:0]];
   end

   // R10: a banked write with an out-of-range device number leaves the read value at zero
   a_r10_no_phantom_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_bank && !ldn_ok) |=> (rd_val == 8'h00 || ptr != $past(ptr)));

   // R6: writes to the ID bytes never disturb their read value
   a_r6_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ptr == REG_ID_HI) |=> (ptr != $past(ptr) || rd_val == ID_HI));
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
   import cfgport_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] IDX_PORT = 16'h002E,
   parameter int          N_LDN    = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata
);
   localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_PORT);
   localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(IDX_PORT) + ADDR_W'(1);

   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_aw
      $error("cfgport_top: ADDR_W must be 8..16");
   end

   logic  idx_hit, dat_hit, unlocked, exit_cmd, reg_wr;
   byte_t ptr, rd_val;

   assign idx_hit = (io_addr == IDX_A);
   assign dat_hit = (io_addr == DAT_A);
   assign reg_wr  = io_wr && dat_hit && unlocked;

   cfgport_key u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (io_wr && idx_hit),
      .wdata    (io_wdata),
      .relock   (exit_cmd),
      .unlocked (unlocked)
   );

   cfgport_regs #(.N_LDN(N_LDN)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .ptr      (ptr),
      .wdata    (io_wdata),
      .rd_val   (rd_val),
      .exit_cmd (exit_cmd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr      <= 8'h00;
         io_rdata <= 8'hFF;
      end else begin
         if (io_wr && idx_hit && unlocked) ptr <= io_wdata;
         if (io_rd) begin
            if (unlocked && idx_hit)      io_rdata <= ptr;
            else if (unlocked && dat_hit) io_rdata <= rd_val;
            else                          io_rdata <= 8'hFF;
         end
      end
   end

   // R4: sealed data-port reads return all ones
   a_r4_sealed_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && dat_hit && !unlocked) |=> (io_rdata == 8'hFF));

   // R9: the exit command on the data port seals the file on the next edge
   a_r9_exit_seals: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && dat_hit && unlocked && ptr == REG_CMD && io_wdata == CMD_EXIT) |=> !unlocked);

   // R11: read data holds when no read strobe is present
   a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |=> $stable(io_rdata));
endmodule

// File: tb/cfgport_tb.sv
`timescale 1ns/1ps
module cfgport_top_tb_top;
   localparam logic [15:0] IDX = 16'h002E;
   localparam logic [15:0] DAT = 16'h002F;
   localparam int N_LDN = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h0000;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   cfgport_top #(.N_LDN(N_LDN)) dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata));

   task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      d = io_rdata;
   endtask

   task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
      io_write(IDX, idx);
      io_write(DAT, val);
   endtask

   task automatic get_reg(input logic [7:0] idx, output logic [7:0] val);
      io_write(IDX, idx);
      io_read(DAT, val);
   endtask

   task automatic send_key();
      io_write(IDX, 8'h87); io_write(IDX, 8'h01);
      io_write(IDX, 8'h55); io_write(IDX, 8'h55);
   endtask

   function automatic logic [7:0] bank_pat(input int ldn, input int idx);
      return 8'((ldn * 37 + idx * 5 + 3) & 8'hFF);
   endfunction

   function automatic logic [7:0] glob_exp(input int idx, input logic [7:0] ldn);
      if (idx == 2)         return 8'h00;
      else if (idx == 7)    return ldn;
      else if (idx == 8'h20) return 8'h87;
      else if (idx == 8'h21) return 8'h20;
      else                  return 8'(idx) ^ 8'hA5;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(io_rdata, 8'hFF, "R1 rdata after reset");
      io_read(DAT, v); chk(v, 8'hFF, "R1 sealed after reset");

      // R4: sealed accesses
      io_write(DAT, 8'h5A);
      io_read(IDX, v); chk(v, 8'hFF, "R4 sealed index read");
      io_read(DAT, v); chk(v, 8'hFF, "R4 sealed data read");

      // R3: broken key stays sealed
      io_write(IDX, 8'h87); io_write(IDX, 8'h01); io_write(IDX, 8'h12);
      io_write(IDX, 8'h55); io_write(IDX, 8'h55);
      io_read(IDX, v); chk(v, 8'hFF, "R3 broken key stays sealed");
      io_write(IDX, 8'h87); io_write(IDX, 8'h01); io_write(IDX, 8'h55);
      io_write(IDX, 8'h87);
      io_read(IDX, v); chk(v, 8'hFF, "R3 partial key sealed");
      io_write(IDX, 8'h01); io_write(IDX, 8'h55); io_write(IDX, 8'h55);
      io_read(IDX, v); chk(v, 8'h00, "R3 stray lead byte counts, R2 open index read");

      // R4: sealed data write earlier left register 0x00 untouched
      get_reg(8'h00, v); chk(v, 8'h00, "R4 sealed write dropped");
      get_reg(8'h07, v); chk(v, 8'h00, "R1 device select reset");

      // R2: index read returns pointer
      io_write(IDX, 8'h3C);
      io_read(IDX, v); chk(v, 8'h3C, "R2 pointer readback");

      // R5/R6: global sweep with ID write attempts
      for (int i = 0; i < 48; i++)
         if (i != 2 && i != 7 && i != 8'h20 && i != 8'h21) set_reg(8'(i), 8'(i) ^ 8'hA5);
      set_reg(8'h20, 8'h11); set_reg(8'h21, 8'h22);
      for (int i = 0; i < 48; i++) begin
         get_reg(8'(i), v); chk(v, glob_exp(i, 8'h00), "R5 R6 global readback");
      end

      // R9: non-exit value to command register keeps it open
      set_reg(8'h02, 8'h03);
      get_reg(8'h02, v); chk(v, 8'h00, "R9 command reads zero");
      io_read(IDX, v); chk(v, 8'h02, "R9 wrong command keeps open");

      // R7: fill every bank
      for (int l = 0; l < N_LDN; l++) begin
         set_reg(8'h07, 8'(l));
         for (int i = 8'h30; i < 256; i++) set_reg(8'(i), bank_pat(l, i));
      end
      for (int l = N_LDN - 1; l >= 0; l--) begin
         set_reg(8'h07, 8'(l));
         for (int i = 8'h30; i < 256; i++) begin
            get_reg(8'(i), v); chk(v, bank_pat(l, i), "R7 bank readback");
         end
      end

      // R8: globals shared under a different device number
      set_reg(8'h07, 8'h03);
      for (int i = 0; i < 48; i++) begin
         get_reg(8'(i), v); chk(v, glob_exp(i, 8'h03), "R8 shared global");
      end

      // R10: out-of-range device numbers
      set_reg(8'h07, 8'(N_LDN));
      set_reg(8'h40, 8'hEE);
      get_reg(8'h40, v); chk(v, 8'h00, "R10 out-of-range read");
      set_reg(8'h07, 8'hFF);
      get_reg(8'hFF, v); chk(v, 8'h00, "R10 top device number read");
      set_reg(8'h07, 8'h00);
      get_reg(8'h40, v); chk(v, bank_pat(0, 8'h40), "R10 bank 0 not clobbered");

      // R11: other addresses and hold
      io_read(16'h002D, v); chk(v, 8'hFF, "R11 foreign address read");
      io_read(16'h012E, v); chk(v, 8'hFF, "R11 aliased address read");
      get_reg(8'h21, v);
      repeat (5) @(negedge clk);
      chk(io_rdata, 8'h20, "R11 rdata holds between reads");

      // R9: exit seals, contents survive, reopen
      set_reg(8'h02, 8'h02);
      io_read(DAT, v); chk(v, 8'hFF, "R9 exit seals data port");
      io_read(IDX, v); chk(v, 8'hFF, "R9 exit seals index port");
      send_key();
      get_reg(8'h10, v); chk(v, 8'h10 ^ 8'hA5, "R9 global kept across exit");
      get_reg(8'h80, v); chk(v, bank_pat(0, 8'h80), "R9 bank kept across exit");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule